// File: doc/BRIEF.md
# Quarter-Clock Resolution PWM Generator

This block drives one pulse-width-modulated switch signal for a power converter. Its pulse edge can be placed to a quarter of a system clock period. Upstream logic gives the on-time as a count of quarter-clock steps, called quadrants. A coarse counter steps through the whole clock periods of one switching period. In the single clock period where the pulse ends, the two least significant bits of the on-time pick which of four clock phases (0, 90, 180 or 270 degrees) turns the output off.

With the defaults, the block runs from a 50 MHz clock and switches at 100 kHz. One period is 500 clocks, or 2000 quadrants, so the edge step is 5 ns. With whole-clock steps only, the duty step would be 0.2 %.

The block does not drive a pin directly. Each clock it presents a four-bit level pattern, one bit per quadrant, in phase order. An output cell clocked by the four phase-shifted clocks turns that pattern into the pin waveform. The on-time is double buffered: a write goes into a holding register, and the running period picks it up only at its start. A one-clock strobe marks each period start, so the controller knows when to supply the next value.

Top module: `hrpwm_quad`

## Requirements
- R1: While `rst_n` is low, `pwm_quad` is 0 and `period_start` is 0.
- R2: `period_start` is high for exactly one clock in every 500 clocks. It is first high in the first clock after reset is released.
- R3: Let c be the clock index within a period, with c = 0 in the clock where `period_start` is high, and let D be the active on-time. Bit k of `pwm_quad` is 1 if and only if 4*c + k < D. Bit 0 is the 0-degree quadrant and bit 3 is the 270-degree quadrant.
- R4: A value written with `duty_wr` becomes active only at the next period start. It has no effect on the pattern of the period in which it is written.
- R5: A written value above 2000 is stored as 2000.
- R6: An active on-time of 0 keeps every bit of `pwm_quad` low for the whole period. An active on-time of 2000 keeps every bit high for the whole period. The on-time is 0 after reset, until a write takes effect.
- R7: When several writes fall within one period, the last one is the value that becomes active.
- R8: In every clock, `pwm_quad` is one of 4'b0000, 4'b0001, 4'b0011, 4'b0111 or 4'b1111.
- R9: Once bit 3 of `pwm_quad` has been low within a period, `pwm_quad` stays 0 until the next period start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all quadrant phases are derived from it |
| rst_n | input | 1 | Asynchronous reset, active low |
| duty_wr | input | 1 | Write strobe for the on-time holding register |
| duty_in | input | 11 | On-time in quadrants; values above 2000 are clamped |
| pwm_quad | output | 4 | Output levels for the four quadrants of the current clock, bit 0 first in time |
| period_start | output | 1 | One-clock strobe marking clock 0 of each period |

## Verification
The bench uses on-times that end in each of the four quadrants of an early clock: 1, 2, 3, 4 and 5. An off-by-one in the fine comparison would show up there as a pattern shifted by a single quadrant. It also tests the extremes 0, 1999 and 2000, and a write of 2047. A design that wrapped instead of clamping would give a short pulse for 2047. A design that mishandled the last clock would either drop the final quadrant at 1999 or glitch low at 2000. Every write happens mid-period, so an unbuffered load would change the running pattern partway through. Two writes in one period show whether the later value wins.

// File: rtl/hrpwm_pkg.sv
package hrpwm_pkg;
    // Default timing: 50 MHz clock, 100 kHz switching, four phase quadrants.
    localparam int unsigned DEF_PERIOD_CLKS = 500;
    localparam int unsigned DEF_PH_BITS     = 2;

    // Saturating limit on a requested on-time.
    function automatic logic [15:0] sat_duty(input logic [15:0] req,
                                             input logic [15:0] lim);
        return (req > lim) ? lim : req;
    endfunction
endpackage

// File: rtl/hrpwm_timebase.sv
module hrpwm_timebase #(
    parameter int unsigned PERIOD_CLKS = hrpwm_pkg::DEF_PERIOD_CLKS,
    parameter int unsigned CNT_W       = $clog2(PERIOD_CLKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             wrap,
    output logic             strobe
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CLKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             strb;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        wrap      = (st_q.cnt == LAST);
        st_d.cnt  = wrap ? '0 : st_q.cnt + 1'b1;
        st_d.strb = wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= LAST;
            st_q.strb <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_nxt = st_d.cnt;
    assign strobe  = st_q.strb;

    assert_strobe_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.strb |-> (st_q.cnt == '0));
    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);
    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.strb |=> !st_q.strb);
endmodule

// File: rtl/hrpwm_duty_buf.sv
module hrpwm_duty_buf #(
    parameter int unsigned DUTY_W   = 11,
    parameter int unsigned DUTY_MAX = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DUTY_W-1:0] din,
    input  logic              wrap,
    output logic [DUTY_W-1:0] act_nxt
);
    localparam logic [DUTY_W-1:0] LIM = DUTY_W'(DUTY_MAX);

    typedef struct packed {
        logic [DUTY_W-1:0] shd;
        logic [DUTY_W-1:0] act;
    } buf_state_t;

    buf_state_t st_d, st_q;
    logic [15:0] sat_w;

    always_comb begin
        st_d  = st_q;
        sat_w = hrpwm_pkg::sat_duty(16'(din), 16'(LIM));
        if (wr)
            st_d.shd = sat_w[DUTY_W-1:0];
        if (wrap)
            st_d.act = st_q.shd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_nxt = st_d.act;

    assert_hold_mid_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(st_q.act));
    assert_shadow_clamped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.shd <= LIM);
    assert_last_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && din <= LIM) |=> (st_q.shd == $past(din)));
endmodule

// File: rtl/hrpwm_phase_sel.sv
module hrpwm_phase_sel #(
    parameter int unsigned CNT_W   = 9,
    parameter int unsigned PH_BITS = hrpwm_pkg::DEF_PH_BITS,
    parameter int unsigned DUTY_W  = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CNT_W-1:0]         cnt_nxt,
    input  logic [DUTY_W-1:0]        duty_nxt,
    output logic [(1<<PH_BITS)-1:0]  pat
);
    localparam int unsigned NPH   = 1 << PH_BITS;
    localparam int unsigned CMP_W = ((CNT_W + PH_BITS) > DUTY_W ? (CNT_W + PH_BITS) : DUTY_W) + 1;

    typedef struct packed {
        logic [NPH-1:0] pat;
    } ps_state_t;

    ps_state_t      st_d, st_q;
    logic [NPH-1:0] lvl;

    // One comparator per quadrant: quadrant index of the next clock vs. on-time.
    for (genvar k = 0; k < NPH; k++) begin : g_quad
        logic [CMP_W-1:0] q_idx;
        assign q_idx  = CMP_W'({cnt_nxt, PH_BITS'(k)});
        assign lvl[k] = (q_idx < CMP_W'(duty_nxt));
    end

    always_comb begin
        st_d     = st_q;
        st_d.pat = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pat = st_q.pat;

    // Thermometer shape: adding one to the pattern yields a power of two.
    assert_thermometer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.pat & (st_q.pat + 1'b1)) && ((st_q.pat & (st_q.pat + 1'b1)) == '0));
endmodule

// File: rtl/hrpwm_quad.sv
module hrpwm_quad #(
    parameter int unsigned PERIOD_CLKS = hrpwm_pkg::DEF_PERIOD_CLKS,
    parameter int unsigned PH_BITS     = hrpwm_pkg::DEF_PH_BITS,
    parameter int unsigned NPH         = 1 << PH_BITS,
    parameter int unsigned DUTY_MAX    = PERIOD_CLKS * NPH,
    parameter int unsigned DUTY_W      = $clog2(DUTY_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              duty_wr,
    input  logic [DUTY_W-1:0] duty_in,
    output logic [NPH-1:0]    pwm_quad,
    output logic              period_start
);
    localparam int unsigned CNT_W = $clog2(PERIOD_CLKS);

    logic [CNT_W-1:0]  cnt_nxt;
    logic              wrap;
    logic [DUTY_W-1:0] act_nxt;

    hrpwm_timebase #(
        .PERIOD_CLKS(PERIOD_CLKS),
        .CNT_W      (CNT_W)
    ) u_timebase (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_nxt(cnt_nxt),
        .wrap   (wrap),
        .strobe (period_start)
    );

    hrpwm_duty_buf #(
        .DUTY_W  (DUTY_W),
        .DUTY_MAX(DUTY_MAX)
    ) u_duty_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (duty_wr),
        .din    (duty_in),
        .wrap   (wrap),
        .act_nxt(act_nxt)
    );

    hrpwm_phase_sel #(
        .CNT_W  (CNT_W),
        .PH_BITS(PH_BITS),
        .DUTY_W (DUTY_W)
    ) u_phase_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_nxt (cnt_nxt),
        .duty_nxt(act_nxt),
        .pat     (pwm_quad)
    );

    // After the pulse has ended, nothing rises again before the next period.
    assert_no_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_quad[NPH-1] && !wrap) |=> (pwm_quad == '0));
    // Period start and the pulse: the first clock is full high unless the on-time is below one clock.
    assert_start_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (period_start && pwm_quad[NPH-1]) |-> (pwm_quad == '1));
endmodule

// File: tb/hrpwm_quad_test.sv
`timescale 1ns/1ps
module hrpwm_quad_test;
    localparam int PER = 500;
    localparam int MAXD = 2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        duty_wr = 1'b0;
    logic [10:0] duty_in = '0;
    logic [3:0]  pwm_quad;
    logic        period_start;

    int checks = 0;
    int fails  = 0;
    int exp_duty[$];
    string exp_tag[$];
    bit mon_done = 1'b0;

    always #2.5 clk = ~clk;

    hrpwm_quad uut (
        .clk(clk), .rst_n(rst_n), .duty_wr(duty_wr), .duty_in(duty_in),
        .pwm_quad(pwm_quad), .period_start(period_start)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_pat(input int d, input int c);
        logic [3:0] p;
        for (int k = 0; k < 4; k++) p[k] = ((4 * c + k) < d);
        return p;
    endfunction

    task automatic wait_strobe();
        do begin
            @(posedge clk); #1;
        end while (!period_start);
    endtask

    task automatic write_duty(input int v);
        @(negedge clk);
        duty_wr = 1'b1;
        duty_in = 11'(v);
        @(negedge clk);
        duty_wr = 1'b0;
    endtask

    // Driver: one expected item per period, written mid-period (R4).
    task automatic drive_period(input int v, input string tag);
        wait_strobe();
        repeat (37) @(negedge clk);
        write_duty(v);
        exp_duty.push_back(v > MAXD ? MAXD : v);
        exp_tag.push_back(tag);
    endtask

    // Monitor: pops one item at each period start and compares every clock.
    initial begin : monitor
        int cur = 0, idx = 0, bad = 0, shape_bad = 0, first_a = 0, first_e = 0;
        bit active = 1'b0, fell = 1'b0;
        string tag = "";
        @(posedge rst_n);
        forever begin
            @(posedge clk); #1;
            if (period_start) begin
                if (active) begin
                    check(idx == PER - 1, "R2", "strobe spacing", idx + 1, PER);
                    check(bad == 0, tag, $sformatf("pattern duty %0d", cur), first_a, first_e);
                    check(shape_bad == 0, "R8 R9", "pattern shape", shape_bad, 0);
                end
                if (exp_duty.size() == 0) begin
                    mon_done = 1'b1;
                    break;
                end
                cur = exp_duty.pop_front();
                tag = exp_tag.pop_front();
                idx = 0; bad = 0; shape_bad = 0; fell = 1'b0; active = 1'b1;
            end else begin
                idx++;
                if (idx >= PER) begin
                    check(1'b0, "R2", "missing strobe", idx, PER - 1);
                    idx = 0;
                end
            end
            if (active) begin
                if (pwm_quad !== ref_pat(cur, idx) && bad == 0) begin
                    first_a = int'(pwm_quad);
                    first_e = int'(ref_pat(cur, idx));
                end
                if (pwm_quad !== ref_pat(cur, idx)) bad++;
                if (!(pwm_quad inside {4'b0000, 4'b0001, 4'b0011, 4'b0111, 4'b1111})) shape_bad++;
                if (fell && pwm_quad != 4'b0000) shape_bad++;
                if (!pwm_quad[3]) fell = 1'b1;
            end
        end
    end

    initial begin : watchdog
        #(200000 * 5);
        check(1'b0, "WATCHDOG", "run timed out", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : driver
        repeat (4) @(negedge clk);
        check(pwm_quad == 4'b0000, "R1", "pwm_quad in reset", int'(pwm_quad), 0);
        check(period_start == 1'b0, "R1", "period_start in reset", int'(period_start), 0);
        exp_duty.push_back(0);
        exp_tag.push_back("R6 reset on-time zero");
        @(negedge clk);
        rst_n = 1'b1;
        drive_period(1,    "R3 quadrant 0");
        drive_period(2,    "R3 quadrant 1");
        drive_period(3,    "R3 quadrant 2");
        drive_period(4,    "R3 whole clock");
        drive_period(5,    "R3 next clock");
        drive_period(1003, "R3 R4 mid value");
        drive_period(1999, "R3 one short");
        drive_period(2000, "R6 full high");
        drive_period(2047, "R5 clamp");
        drive_period(0,    "R6 full low");
        // R7: two writes in one period, the later one must win.
        wait_strobe();
        repeat (20) @(negedge clk);
        write_duty(7);
        repeat (50) @(negedge clk);
        write_duty(1234);
        exp_duty.push_back(1234);
        exp_tag.push_back("R7 last write");
        wait (mon_done);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule